// File: doc/BRIEF.md
# Serial Configuration Loader

The loader brings up a target device that takes its configuration through a serial slave interface. After a start pulse it drives the program line, clock and data to their idle levels and then asserts program. It then runs a handshake with three waits. The first wait is for INIT to fall. Program is then released, and the second wait is for INIT to rise. The third wait comes after the stream has been sent and is for DONE to rise. Each wait has its own timeout and its own result code.

Between the second and third waits, the block sends a fixed 16-bit sync word. It then sends bits that an upstream producer offers one at a time through a valid/ready handshake, and the producer marks the final bit. Each bit takes four timed phases, and the target samples data on the rising edge of the configuration clock. A prescaler sets the length of each phase and also produces the millisecond tick that paces the status polling.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, progOut is at its inactive level, cclkOut and dataOut are 1, and busy and resultValid are 0.
- R2: A start pulse raises busy and drives progOut to its active level. If INIT is still high when the polling gives up, resultCode is 1 (failure -1).
- R3: If INIT falls but does not rise again after program is released, resultCode is 2 (failure -2).
- R4: If DONE stays low after the last bit, resultCode is 3 (failure -3).
- R5: A full handshake posts resultCode 0. resultValid is a one-cycle pulse, and afterwards progOut is inactive and cclkOut and dataOut are 1.
- R6: A wait polls its status line on entry and at each millisecond tick. It fails at the fifth tick after entry, when the poll counter has passed 3. A stuck INIT-low wait therefore posts its result 5*MS_CLKS+1 clocks after progOut goes active.
- R7: Each bit has four phases of PHASE_CLKS clocks: clock low with data 1, clock low with the bit, clock high with the bit, clock high with data 1. cclkOut is low for exactly 2*PHASE_CLKS clocks per bit, dataOut holds the bit at the rising edge, and dataOut is 1 at every falling edge.
- R8: With SEND_PREAMBLE=1, the bytes 0xFF and then 0x20 are sent MSB first before any stream bit.
- R9: bitReady is high only while streaming with the serializer idle. A bit transfers on bitValid && bitReady, and the transfer carrying bitLast ends the stream. Exactly 16 plus the stream length rising edges appear.
- R10: With PROG_ACTIVE_HIGH=0 the active level of progOut is 0. With PROG_ACTIVE_HIGH=1 it is 1.
- R11: busy stays high from start until the result is posted. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin a configuration run |
| bitValid | input | 1 | Stream bit offered |
| bitData | input | 1 | Stream bit value |
| bitLast | input | 1 | Offered bit is the final one |
| bitReady | output | 1 | Loader takes the offered bit this cycle |
| initIn | input | 1 | Target INIT status (asynchronous) |
| doneIn | input | 1 | Target DONE status (asynchronous) |
| progOut | output | 1 | Program line to target |
| cclkOut | output | 1 | Configuration clock, idles high |
| dataOut | output | 1 | Configuration data, idles high |
| busy | output | 1 | Run in progress |
| resultValid | output | 1 | One-cycle result strobe |
| resultCode | output | 2 | 0 success, k means failure -k |

## Verification
The case that is hardest to reach from the ports is the second timeout. To reach it, INIT has to fall in answer to program and then stay low after program is released. The bench reaches it with a task that follows progOut and drives INIT at the right moments. The exact failure cycle matters as much as the failure code, so the bench uses a short millisecond period and times the result against the cycle in which progOut went active. One tick too few or too many then shows up as a wrong count. Bit timing is checked by a monitor that watches the clock edges and records the data and the low time at every edge.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PREP, ST_PROG, ST_WAIT_INIT_LO, ST_WAIT_INIT_HI,
    ST_PREAMBLE, ST_STREAM, ST_DRAIN, ST_WAIT_DONE, ST_REPORT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBit;
    logic bitVal;
    logic clearTimer;
  } dpCmd_t;

  localparam logic [1:0] CODE_OK        = 2'd0;
  localparam logic [1:0] CODE_INIT_HIGH = 2'd1;
  localparam logic [1:0] CODE_INIT_LOW  = 2'd2;
  localparam logic [1:0] CODE_NO_DONE   = 2'd3;
  localparam logic [15:0] SYNC_WORD     = 16'hFF20;
endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int PHASE_CLKS = 4,
  parameter int MS_CLKS    = 50000
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   bitBusy,
  output logic   msTick,
  output logic   cclkOut,
  output logic   dataOut
);
  localparam int PH_W = $clog2(PHASE_CLKS + 1);
  localparam int MS_W = $clog2(MS_CLKS + 1);

  logic [PH_W-1:0] phCnt;
  logic [MS_W-1:0] msCnt;
  logic [1:0]      phase;
  logic            bitReg;
  logic            phaseEnd;

  assign phaseEnd = (phCnt == PH_W'(PHASE_CLKS - 1));
  assign msTick   = (msCnt == MS_W'(MS_CLKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt   <= '0;
      phCnt   <= '0;
      phase   <= '0;
      bitBusy <= 1'b0;
      bitReg  <= 1'b1;
    end else begin
      if (cmd.clearTimer || msTick) msCnt <= '0;
      else                          msCnt <= msCnt + 1'b1;

      if (cmd.loadBit) begin
        bitBusy <= 1'b1;
        phase   <= '0;
        phCnt   <= '0;
        bitReg  <= cmd.bitVal;
      end else if (bitBusy) begin
        if (phaseEnd) begin
          phCnt <= '0;
          phase <= phase + 1'b1;
          if (phase == 2'd3) bitBusy <= 1'b0;
        end else begin
          phCnt <= phCnt + 1'b1;
        end
      end
    end
  end

  // phases: 0 low/1, 1 low/bit, 2 high/bit, 3 high/1
  assign cclkOut = bitBusy ? phase[1] : 1'b1;
  assign dataOut = (bitBusy && (phase == 2'd1 || phase == 2'd2)) ? bitReg : 1'b1;

  p_rise_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cclkOut) |-> $stable(dataOut));
  p_fall_data_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cclkOut) |-> dataOut);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rstN)
    !bitBusy |-> (cclkOut && dataOut));
endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int POLL_LIMIT    = 3,
  parameter bit SEND_PREAMBLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       bitValid,
  input  logic       bitData,
  input  logic       bitLast,
  input  logic       initSync,
  input  logic       doneSync,
  input  logic       bitBusy,
  input  logic       msTick,
  output dpCmd_t     cmd,
  output logic       bitReady,
  output logic       progAct,
  output logic       busy,
  output logic       resultValid,
  output logic [1:0] resultCode
);
  localparam int PC_W = $clog2(POLL_LIMIT + 2);

  seqState_e       state, stateNext;
  logic [PC_W-1:0] pollCnt;
  logic [3:0]      preIdx;
  logic            firstPoll;
  logic            inWait, waitMet, overLimit, setCode;
  logic [1:0]      codeNext, failCode;

  assign inWait = (state == ST_WAIT_INIT_LO) || (state == ST_WAIT_INIT_HI) ||
                  (state == ST_WAIT_DONE);
  assign overLimit = (pollCnt > PC_W'(POLL_LIMIT));

  always_comb begin
    case (state)
      ST_WAIT_INIT_LO: begin waitMet = !initSync; failCode = CODE_INIT_HIGH; end
      ST_WAIT_INIT_HI: begin waitMet = initSync;  failCode = CODE_INIT_LOW;  end
      default:         begin waitMet = doneSync;  failCode = CODE_NO_DONE;   end
    endcase
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    bitReady  = 1'b0;
    setCode   = 1'b0;
    codeNext  = CODE_OK;
    case (state)
      ST_IDLE: if (start) stateNext = ST_PREP;
      ST_PREP: stateNext = ST_PROG;
      ST_PROG: begin
        stateNext      = ST_WAIT_INIT_LO;
        cmd.clearTimer = 1'b1;
      end
      ST_WAIT_INIT_LO, ST_WAIT_INIT_HI, ST_WAIT_DONE: begin
        if (msTick && overLimit) begin
          stateNext = ST_REPORT;
          setCode   = 1'b1;
          codeNext  = failCode;
        end else if ((firstPoll || msTick) && waitMet) begin
          if (state == ST_WAIT_INIT_LO) begin
            stateNext      = ST_WAIT_INIT_HI;
            cmd.clearTimer = 1'b1;
          end else if (state == ST_WAIT_INIT_HI) begin
            stateNext = SEND_PREAMBLE ? ST_PREAMBLE : ST_STREAM;
          end else begin
            stateNext = ST_REPORT;
            setCode   = 1'b1;
          end
        end
      end
      ST_PREAMBLE: if (!bitBusy) begin
        cmd.loadBit = 1'b1;
        cmd.bitVal  = SYNC_WORD[4'd15 - preIdx];
        if (preIdx == 4'd15) stateNext = ST_STREAM;
      end
      ST_STREAM: begin
        bitReady = !bitBusy;
        if (bitReady && bitValid) begin
          cmd.loadBit = 1'b1;
          cmd.bitVal  = bitData;
          if (bitLast) stateNext = ST_DRAIN;
        end
      end
      ST_DRAIN: if (!bitBusy) begin
        stateNext      = ST_WAIT_DONE;
        cmd.clearTimer = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pollCnt    <= '0;
      preIdx     <= '0;
      firstPoll  <= 1'b0;
      resultCode <= CODE_OK;
    end else begin
      state     <= stateNext;
      firstPoll <= cmd.clearTimer;
      if (cmd.clearTimer)         pollCnt <= '0;
      else if (inWait && msTick)  pollCnt <= pollCnt + 1'b1;
      if (state == ST_PROG)                        preIdx <= '0;
      else if (state == ST_PREAMBLE && cmd.loadBit) preIdx <= preIdx + 1'b1;
      if (setCode) resultCode <= codeNext;
    end
  end

  assign progAct     = (state == ST_PROG) || (state == ST_WAIT_INIT_LO);
  assign busy        = (state != ST_IDLE) && (state != ST_REPORT);
  assign resultValid = (state == ST_REPORT);

  p_result_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !busy);
  p_prog_in_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    progAct |-> busy);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> !bitBusy);
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    inWait |-> (pollCnt <= PC_W'(POLL_LIMIT + 1)));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int PHASE_CLKS       = 4,
  parameter int MS_CLKS          = 50000,
  parameter int POLL_LIMIT       = 3,
  parameter bit PROG_ACTIVE_HIGH = 1'b0,
  parameter bit SEND_PREAMBLE    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       bitValid,
  input  logic       bitData,
  input  logic       bitLast,
  output logic       bitReady,
  input  logic       initIn,
  input  logic       doneIn,
  output logic       progOut,
  output logic       cclkOut,
  output logic       dataOut,
  output logic       busy,
  output logic       resultValid,
  output logic [1:0] resultCode
);
  dpCmd_t     cmd;
  logic       bitBusy, msTick, progAct;
  logic [1:0] initPipe, donePipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initPipe <= '0;
      donePipe <= '0;
    end else begin
      initPipe <= {initPipe[0], initIn};
      donePipe <= {donePipe[0], doneIn};
    end
  end

  cfg_loader_ctrl #(.POLL_LIMIT(POLL_LIMIT), .SEND_PREAMBLE(SEND_PREAMBLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bitValid(bitValid), .bitData(bitData),
    .bitLast(bitLast), .initSync(initPipe[1]), .doneSync(donePipe[1]),
    .bitBusy(bitBusy), .msTick(msTick), .cmd(cmd), .bitReady(bitReady),
    .progAct(progAct), .busy(busy), .resultValid(resultValid), .resultCode(resultCode)
  );

  cfg_loader_dp #(.PHASE_CLKS(PHASE_CLKS), .MS_CLKS(MS_CLKS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bitBusy(bitBusy), .msTick(msTick),
    .cclkOut(cclkOut), .dataOut(dataOut)
  );

  generate
    if (PROG_ACTIVE_HIGH) begin : g_prog_hi
      assign progOut = progAct;
    end else begin : g_prog_lo
      assign progOut = ~progAct;
    end
  endgenerate
endmodule

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  localparam int PH = 2;
  localparam int MS = 20;
  localparam int NSTREAM = 12;
  localparam logic [11:0] STREAM = 12'b1011_0010_0110;

  logic clk = 0, rstN = 0;
  logic start = 0, bitValid = 0, bitData = 0, bitLast = 0, initIn = 1, doneIn = 0;
  logic bitReady, progOut, cclkOut, dataOut, busy, resultValid;
  logic [1:0] resultCode;
  logic startHi = 0, progHi, unusedRdy, unusedClk, unusedDat, unusedBusy, unusedVld;
  logic [1:0] unusedCode;

  int errors = 0, checks = 0, cyc = 0, pulseCnt = 0;
  int rxCnt = 0, lowErr = 0, fallErr = 0;
  logic rxBits [0:63];
  time fallT = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (rstN && resultValid) pulseCnt++;

  cfg_serial_loader #(.PHASE_CLKS(PH), .MS_CLKS(MS)) dut (
    .clk(clk), .rstN(rstN), .start(start), .bitValid(bitValid), .bitData(bitData),
    .bitLast(bitLast), .bitReady(bitReady), .initIn(initIn), .doneIn(doneIn),
    .progOut(progOut), .cclkOut(cclkOut), .dataOut(dataOut), .busy(busy),
    .resultValid(resultValid), .resultCode(resultCode));

  cfg_serial_loader #(.PHASE_CLKS(PH), .MS_CLKS(MS), .PROG_ACTIVE_HIGH(1'b1)) dutHi (
    .clk(clk), .rstN(rstN), .start(startHi), .bitValid(1'b0), .bitData(1'b0),
    .bitLast(1'b0), .bitReady(unusedRdy), .initIn(1'b1), .doneIn(1'b0),
    .progOut(progHi), .cclkOut(unusedClk), .dataOut(unusedDat), .busy(unusedBusy),
    .resultValid(unusedVld), .resultCode(unusedCode));

  always @(negedge cclkOut) if (rstN) begin
    fallT = $time;
    if (dataOut !== 1'b1) fallErr++;
  end
  always @(posedge cclkOut) if (rstN) begin
    if (rxCnt < 64) rxBits[rxCnt] = dataOut;
    rxCnt++;
    if ($time - fallT != 2 * PH * 20) lowErr++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic waitResult(output int atCyc);
    int guard = 0;
    while (!resultValid && guard < 5000) begin @(negedge clk); guard++; end
    atCyc = cyc;
  endtask

  task automatic feedBits(input logic [31:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitValid = 1; bitData = pat[n-1-i]; bitLast = (i == n-1);
      while (!bitReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); bitValid = 0; bitLast = 0;
  endtask

  task automatic initHandshake;
    while (progOut !== 1'b0) @(negedge clk);
    initIn = 0;
    while (progOut !== 1'b1) @(negedge clk);
    repeat (5) @(negedge clk);
    initIn = 1;
  endtask

  task automatic testReset;
    check(progOut == 1'b1, "R1 prog inactive", progOut, 1);
    check(cclkOut == 1'b1 && dataOut == 1'b1, "R1 clk/data high", {cclkOut, dataOut}, 3);
    check(busy == 0 && resultValid == 0, "R1 flags low", {busy, resultValid}, 0);
    check(progHi == 1'b0, "R10 active-high idle", progHi, 0);
  endtask

  task automatic testSuccess;
    int tR, p0;
    logic [15:0] pre; logic [11:0] str;
    rxCnt = 0; lowErr = 0; fallErr = 0; initIn = 1; doneIn = 0; p0 = pulseCnt;
    pulseStart;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    fork
      begin feedBits({20'd0, STREAM}, NSTREAM); @(negedge clk); doneIn = 1; end
    join_none
    while (progOut !== 1'b0) @(negedge clk);
    check(bitReady == 1'b0, "R9 no ready while waiting", bitReady, 0);
    check(progOut == 1'b0, "R10 active-low asserted", progOut, 0);
    initHandshake;
    waitResult(tR);
    check(resultCode == 2'd0, "R5 success code", resultCode, 0);
    @(negedge clk);
    check(resultValid == 0 && busy == 0, "R5 single pulse", {resultValid, busy}, 0);
    check(progOut && cclkOut && dataOut, "R5 pins idle", {progOut, cclkOut, dataOut}, 7);
    check(rxCnt == 16 + NSTREAM, "R9 edge count", rxCnt, 16 + NSTREAM);
    for (int i = 0; i < 16; i++) pre[15-i] = rxBits[i];
    for (int i = 0; i < NSTREAM; i++) str[NSTREAM-1-i] = rxBits[16+i];
    check(pre == 16'hFF20, "R8 sync word", pre, 16'hFF20);
    check(str == STREAM, "R9 stream bits", str, STREAM);
    check(lowErr == 0, "R7 clock low time", lowErr, 0);
    check(fallErr == 0, "R7 data high at fall", fallErr, 0);
    check(pulseCnt - p0 == 1, "R5 one result", pulseCnt - p0, 1);
    doneIn = 0;
  endtask

  task automatic testInitStuckHigh;
    int tP, tR, p0;
    initIn = 1; p0 = pulseCnt;
    pulseStart;
    while (progOut !== 1'b0) @(negedge clk);
    tP = cyc;
    repeat (30) @(negedge clk);
    pulseStart;  // ignored while busy
    check(busy == 1'b1, "R11 busy mid-wait", busy, 1);
    waitResult(tR);
    check(resultCode == 2'd1, "R2 init-low timeout code", resultCode, 1);
    check(tR - tP >= 5*MS && tR - tP <= 5*MS + 3, "R6 timeout cycle", tR - tP, 5*MS + 1);
    repeat (5) @(negedge clk);
    check(pulseCnt - p0 == 1 && busy == 0, "R11 restart ignored", pulseCnt - p0, 1);
  endtask

  task automatic testInitStuckLow;
    int tR;
    initIn = 1;
    pulseStart;
    while (progOut !== 1'b0) @(negedge clk);
    initIn = 0;
    waitResult(tR);
    check(resultCode == 2'd2, "R3 init-high timeout code", resultCode, 2);
    initIn = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic testNoDone;
    int tR;
    initIn = 1; doneIn = 0;
    pulseStart;
    fork feedBits(32'b101, 3); join_none
    initHandshake;
    waitResult(tR);
    check(resultCode == 2'd3, "R4 done timeout code", resultCode, 3);
    repeat (3) @(negedge clk);
  endtask

  task automatic testPolarity;
    @(negedge clk); startHi = 1;
    @(negedge clk); startHi = 0;
    repeat (2) @(negedge clk);
    check(progHi == 1'b1, "R10 active-high asserted", progHi, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset;
    testPolarity;
    testSuccess;
    testInitStuckHigh;
    testInitStuckLow;
    testNoDone;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule